// File: doc/BRIEF.md
# PCI Configuration Command and Status Error Latch

This block holds the command word and the status word that share one dword of a PCI function's configuration header. Configuration software reads both halves together and writes them with per-byte enables. Writes to the command half set the enables that gate the I/O decoder, the memory decoder and the expansion-ROM decoder. The command half also holds the two enables for parity-error response and system-error signalling.

The bus interface sends single-cycle event strobes to the block. The block qualifies each one and latches it into one of four sticky status flags. The flags cover these cases:
- a detected parity error, taken only from a fixed set of qualified bus phases;
- a signalled system error;
- a master abort that ended the device's own cycle;
- a target abort received from the other side.

Software clears a flag by writing a 1 to it. The block also drives two combinational strobes for the pin drivers elsewhere. One reports a system error and the other reports a data parity error.

The only thing that clears the flags and the enables is the hard reset. No other reset or stop condition reaches this block. Unimplemented bits read as zero.

Top module: `cfg_cmdstat_regs`

## Requirements
- R1: After hard reset (`rst_n` low) every implemented bit is 0, so the dword reads 0x00000000 and `io_en`, `mem_en` and `rom_dec_en` are 0.
- R2: A write hitting dword index 1 updates command bits only in bytes whose enable is 1. Byte 0 holds the I/O enable (bit 0), the memory enable (bit 1) and the parity-response enable (bit 6). Byte 1 holds the system-error enable (dword bit 8). The new value is readable in the cycle after the write.
- R3: Every bit outside the mask 0xF0000143 reads 0, and writing it has no effect. A read that is not addressed to dword index 1, or a cycle with `cfg_rd` low, returns 0.
- R4: The parity-error flag (dword bit 31) sets in the cycle after any of these events, whatever the value of the parity-response enable:
  - a parity error in an address phase;
  - a parity error in a slave write data phase that selects the device while TRDY and IRDY are both active;
  - a parity error in a master memory-read data phase while TRDY and IRDY are both active;
  - a target PERR report during a master memory-write data phase.
- R5: None of the following sets the parity-error flag: a parity error in a slave write phase that lacks TRDY or IRDY, or a raw parity error during a master write without a target PERR report.
- R6: The system-error flag (dword bit 30) and the `serr_evt` output respond only to an address parity error while both the system-error enable and the parity-response enable are 1. `serr_evt` is active in the same cycle as the event. The flag sets in the next cycle.
- R7: A master-abort strobe sets dword bit 29 and a target-abort strobe sets dword bit 28 in the next cycle.
- R8: A status flag clears only on a write to dword index 1 that has byte enable 3 set and a 1 in that flag's bit. Writing 0, or writing with byte enable 3 clear, leaves the flag unchanged.
- R9: If a set event and a software clear of the same flag occur in the same cycle, the flag stays set.
- R10: `rom_dec_en` equals `rom_bar_en` AND the memory enable. `io_en` and `mem_en` mirror command bits 0 and 1.
- R11: `perr_rpt_evt` is active in the same cycle as a qualified slave-write or master-read data parity error, and only while the parity-response enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration dword index |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data (combinational) |
| par_err | input | 1 | Parity mismatch on the current phase |
| ph_addr | input | 1 | Current phase is an address phase |
| ph_slv_wr | input | 1 | Slave I/O, memory or configuration write data phase selecting the device |
| trdy_act | input | 1 | TRDY active |
| irdy_act | input | 1 | IRDY active |
| ph_mst_rd | input | 1 | Master memory-read data phase |
| ph_mst_wr | input | 1 | Master memory-write data phase |
| tgt_perr | input | 1 | Target reported PERR |
| mst_abort | input | 1 | Own master cycle ended by master abort |
| tgt_abort | input | 1 | Own master cycle ended by target abort |
| rom_bar_en | input | 1 | Expansion-ROM base enable from the ROM base register |
| io_en | output | 1 | I/O decode enable |
| mem_en | output | 1 | Memory decode enable |
| rom_dec_en | output | 1 | Expansion-ROM decode enable |
| serr_evt | output | 1 | Qualified system-error strobe |
| perr_rpt_evt | output | 1 | Qualified data-parity report strobe |

## Verification
Some properties are checked on every cycle:
- a parity error from any qualified phase latches the parity flag on the next edge;
- the system-error flag only rises after an address parity error with both enables set;
- a flag stays set unless a matching clear write arrives;
- an abort strobe always wins over a clear in the same cycle;
- the ROM decode never opens without the memory enable;
- the command bits stay stable without an enabled write;
- unimplemented bits read zero.

The bench scenarios show the rest. They check exact readback values under different byte-enable patterns and show that phases missing a qualifier are rejected. They confirm that the parity-response enable has no influence on the parity flag. They also observe the same-cycle strobes that go to the pin drivers.

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int CFG_DW     = 32;
    localparam int CFG_BE_W   = CFG_DW / 8;
    localparam int HALF_W     = CFG_DW / 2;

    // command half bit positions (low 16 bits of the dword)
    localparam int CMD_IOEN   = 0;
    localparam int CMD_MEMEN  = 1;
    localparam int CMD_PRSPEN = 6;
    localparam int CMD_SERREN = 8;

    // status flags: index i lives at status bit FLAG_LSB + i
    localparam int NFLAG      = 4;
    localparam int FLAG_LSB   = 12;
    localparam int FL_TABORT  = 0;
    localparam int FL_MABORT  = 1;
    localparam int FL_SERR    = 2;
    localparam int FL_PERR    = 3;

    // dword position of the flag field and the byte holding it
    localparam int FLAG_DW_LSB = HALF_W + FLAG_LSB;
    localparam int FLAG_BYTE   = FLAG_DW_LSB / 8;

    typedef struct packed {
        logic serr_en;
        logic prsp_en;
        logic mem_en;
        logic io_en;
    } cmd_t;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
    } flag_st_t;
endpackage

// File: rtl/cs_event_qual.sv
module cs_event_qual
    import cs_pkg::*;
(
    input  cmd_t             cmd,
    input  logic             par_err,
    input  logic             ph_addr,
    input  logic             ph_slv_wr,
    input  logic             trdy_act,
    input  logic             irdy_act,
    input  logic             ph_mst_rd,
    input  logic             ph_mst_wr,
    input  logic             tgt_perr,
    input  logic             mst_abort,
    input  logic             tgt_abort,
    output logic [NFLAG-1:0] flag_set,
    output logic             serr_evt,
    output logic             perr_rpt_evt
);
    logic xfer;
    logic addr_pe;
    logic slv_data_pe;
    logic mst_rd_pe;
    logic mst_wr_pe;

    always_comb begin
        xfer        = trdy_act & irdy_act;
        addr_pe     = par_err & ph_addr;
        slv_data_pe = par_err & ph_slv_wr & xfer;
        mst_rd_pe   = par_err & ph_mst_rd & xfer;
        mst_wr_pe   = ph_mst_wr & tgt_perr;

        serr_evt     = addr_pe & cmd.serr_en & cmd.prsp_en;
        perr_rpt_evt = (slv_data_pe | mst_rd_pe) & cmd.prsp_en;

        flag_set            = '0;
        flag_set[FL_PERR]   = addr_pe | slv_data_pe | mst_rd_pe | mst_wr_pe;
        flag_set[FL_SERR]   = serr_evt;
        flag_set[FL_MABORT] = mst_abort;
        flag_set[FL_TABORT] = tgt_abort;
    end
endmodule

// File: rtl/cs_cmd_reg.sv
module cs_cmd_reg
    import cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [1:0]        be,
    input  logic [HALF_W-1:0] wdata,
    output cmd_t              cmd_q
);
    cmd_t cmd_d;

    always_comb begin
        cmd_d = cmd_q;
        if (wr_hit && be[CMD_IOEN / 8]) begin
            cmd_d.io_en   = wdata[CMD_IOEN];
            cmd_d.mem_en  = wdata[CMD_MEMEN];
            cmd_d.prsp_en = wdata[CMD_PRSPEN];
        end
        if (wr_hit && be[CMD_SERREN / 8]) begin
            cmd_d.serr_en = wdata[CMD_SERREN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end
endmodule

// File: rtl/cs_flag_bank.sv
module cs_flag_bank
    import cs_pkg::*;
#(
    parameter int N = NFLAG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags_q
);
    logic [N-1:0] flags_d;

    // each flag is sticky; a set in the same cycle overrides a clear
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            flags_d[i] = set[i] | (flags_q[i] & ~clr[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/cfg_cmdstat_regs.sv
module cfg_cmdstat_regs
    import cs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int REG_DW = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_rd,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [CFG_BE_W-1:0] cfg_be,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    output logic [CFG_DW-1:0]   cfg_rdata,
    input  logic                par_err,
    input  logic                ph_addr,
    input  logic                ph_slv_wr,
    input  logic                trdy_act,
    input  logic                irdy_act,
    input  logic                ph_mst_rd,
    input  logic                ph_mst_wr,
    input  logic                tgt_perr,
    input  logic                mst_abort,
    input  logic                tgt_abort,
    input  logic                rom_bar_en,
    output logic                io_en,
    output logic                mem_en,
    output logic                rom_dec_en,
    output logic                serr_evt,
    output logic                perr_rpt_evt
);
    localparam logic [ADDR_W-1:0] HIT_IDX = ADDR_W'(REG_DW);

    logic             addr_hit;
    logic             wr_hit;
    cmd_t             cmd_q;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    logic [NFLAG-1:0] flags_q;
    logic [HALF_W-1:0] cmd_view;
    logic [HALF_W-1:0] sts_view;

    always_comb begin
        addr_hit = (cfg_addr == HIT_IDX);
        wr_hit   = cfg_wr & addr_hit;
        flag_clr = (wr_hit && cfg_be[FLAG_BYTE])
                 ? cfg_wdata[FLAG_DW_LSB +: NFLAG] : '0;
    end

    cs_cmd_reg u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hit(wr_hit),
        .be    (cfg_be[1:0]),
        .wdata (cfg_wdata[HALF_W-1:0]),
        .cmd_q (cmd_q)
    );

    cs_event_qual u_qual (
        .cmd         (cmd_q),
        .par_err     (par_err),
        .ph_addr     (ph_addr),
        .ph_slv_wr   (ph_slv_wr),
        .trdy_act    (trdy_act),
        .irdy_act    (irdy_act),
        .ph_mst_rd   (ph_mst_rd),
        .ph_mst_wr   (ph_mst_wr),
        .tgt_perr    (tgt_perr),
        .mst_abort   (mst_abort),
        .tgt_abort   (tgt_abort),
        .flag_set    (flag_set),
        .serr_evt    (serr_evt),
        .perr_rpt_evt(perr_rpt_evt)
    );

    cs_flag_bank #(.N(NFLAG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (flag_set),
        .clr    (flag_clr),
        .flags_q(flags_q)
    );

    always_comb begin
        cmd_view             = '0;
        cmd_view[CMD_IOEN]   = cmd_q.io_en;
        cmd_view[CMD_MEMEN]  = cmd_q.mem_en;
        cmd_view[CMD_PRSPEN] = cmd_q.prsp_en;
        cmd_view[CMD_SERREN] = cmd_q.serr_en;
        sts_view             = '0;
        sts_view[FLAG_LSB +: NFLAG] = flags_q;
        cfg_rdata = (cfg_rd && addr_hit) ? {sts_view, cmd_view} : '0;
        io_en      = cmd_q.io_en;
        mem_en     = cmd_q.mem_en;
        rom_dec_en = rom_bar_en & cmd_q.mem_en;
    end
endmodule

// File: rtl/cs_checker.sv
module cs_checker
    import cs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int REG_DW = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_rd,
    input logic                cfg_wr,
    input logic [ADDR_W-1:0]   cfg_addr,
    input logic [CFG_BE_W-1:0] cfg_be,
    input logic [CFG_DW-1:0]   cfg_wdata,
    input logic [CFG_DW-1:0]   cfg_rdata,
    input logic                par_err,
    input logic                ph_addr,
    input logic                ph_slv_wr,
    input logic                trdy_act,
    input logic                irdy_act,
    input logic                ph_mst_rd,
    input logic                ph_mst_wr,
    input logic                tgt_perr,
    input logic                mst_abort,
    input logic                io_en,
    input logic                mem_en,
    input logic                rom_dec_en,
    input cmd_t                cmd_q,
    input logic [NFLAG-1:0]    flags_q
);
    localparam logic [CFG_DW-1:0] IMPL_MASK = 32'hF000_0143;
    logic hit_wr;
    logic clr_perr;
    logic clr_mab;

    always_comb begin
        hit_wr   = cfg_wr && (cfg_addr == ADDR_W'(REG_DW));
        clr_perr = hit_wr && cfg_be[3] && cfg_wdata[31];
        clr_mab  = hit_wr && cfg_be[3] && cfg_wdata[29];
    end

    a_r4_perr_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && (ph_addr || ((ph_slv_wr || ph_mst_rd) && trdy_act && irdy_act)))
        || (ph_mst_wr && tgt_perr) |=> flags_q[FL_PERR]);

    a_r6_serr_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[FL_SERR]) |-> $past(par_err && ph_addr && cmd_q.prsp_en && cmd_q.serr_en));

    a_r8_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[FL_PERR] && !clr_perr |=> flags_q[FL_PERR]);

    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mst_abort && clr_mab |=> flags_q[FL_MABORT]);

    a_r10_rom_gate: assert property (@(posedge clk) disable iff (!rst_n)
        rom_dec_en |-> mem_en);

    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_wr && cfg_be[0]) |=> $stable(io_en) && $stable(mem_en));

    a_r3_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |-> (cfg_rdata & ~IMPL_MASK) == '0);
endmodule

bind cfg_cmdstat_regs cs_checker #(.ADDR_W(ADDR_W), .REG_DW(REG_DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .par_err(par_err), .ph_addr(ph_addr),
    .ph_slv_wr(ph_slv_wr), .trdy_act(trdy_act), .irdy_act(irdy_act),
    .ph_mst_rd(ph_mst_rd), .ph_mst_wr(ph_mst_wr), .tgt_perr(tgt_perr),
    .mst_abort(mst_abort), .io_en(io_en), .mem_en(mem_en),
    .rom_dec_en(rom_dec_en), .cmd_q(cmd_q), .flags_q(flags_q)
);

// File: tb/cfg_cmdstat_regs_tb_top.sv
module cfg_cmdstat_regs_tb_top;
    logic clk = 0;
    logic rst_n = 0;
    logic cfg_rd = 0, cfg_wr = 0;
    logic [5:0] cfg_addr = 6'd1;
    logic [3:0] cfg_be = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] cfg_rdata;
    logic par_err = 0, ph_addr = 0, ph_slv_wr = 0, trdy_act = 0, irdy_act = 0;
    logic ph_mst_rd = 0, ph_mst_wr = 0, tgt_perr = 0, mst_abort = 0, tgt_abort = 0;
    logic rom_bar_en = 0;
    logic io_en, mem_en, rom_dec_en, serr_evt, perr_rpt_evt;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    // event bundle: {par,addr,slvwr,trdy,irdy,mstrd,mstwr,tperr,mab,tab}
    localparam logic [9:0] E_ADDR   = 10'b1100000000;
    localparam logic [9:0] E_SLV    = 10'b1011100000;
    localparam logic [9:0] E_SLV_NI = 10'b1011000000;
    localparam logic [9:0] E_MRD    = 10'b1001110000;
    localparam logic [9:0] E_MWR_RAW= 10'b1000001000;
    localparam logic [9:0] E_MWR_TP = 10'b0000001100;
    localparam logic [9:0] E_MAB    = 10'b0000000010;
    localparam logic [9:0] E_TAB    = 10'b0000000001;

    always #5 clk = ~clk;

    cfg_cmdstat_regs dut_i (.*);

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ev(input logic [9:0] e);
        {par_err, ph_addr, ph_slv_wr, trdy_act, irdy_act,
         ph_mst_rd, ph_mst_wr, tgt_perr, mst_abort, tgt_abort} = e;
    endtask

    task automatic rd(input logic [31:0] exp, input string tag, input logic [5:0] a = 6'd1);
        @(posedge clk); #1;
        cfg_rd = 1; cfg_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        cfg_rd = 0; cfg_addr = 6'd1;
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d, input logic [9:0] e = 10'b0);
        @(posedge clk); #1;
        cfg_wr = 1; cfg_be = be; cfg_wdata = d; set_ev(e);
        @(posedge clk); #1;
        cfg_wr = 0; cfg_be = 0; cfg_wdata = 0; set_ev(10'b0);
    endtask

    task automatic pulse(input logic [9:0] e, input logic exp_serr, input logic exp_rpt, input string tag);
        @(posedge clk); #1;
        set_ev(e);
        #2;
        check({31'b0, serr_evt}, {31'b0, exp_serr}, {tag, " serr_evt"});
        check({31'b0, perr_rpt_evt}, {31'b0, exp_rpt}, {tag, " perr_rpt_evt"});
        @(posedge clk); #1;
        set_ev(10'b0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cfg_rd) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard: actual %h expected none", cfg_rdata);
            end else begin
                check(cfg_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check({29'b0, io_en, mem_en, rom_dec_en}, 32'h0, "R1 enables in reset");
        rst_n = 1;
        rd(32'h0, "R1 reset readback");

        wr(4'hF, 32'hFFFF_FFFF);
        rd(32'h0000_0143, "R3 all-ones write masks to implemented bits");
        rd(32'h0, "R3 miss address reads zero", 6'd2);
        #4;
        check({30'b0, io_en, mem_en}, 32'h3, "R10 io_en/mem_en mirror");
        rom_bar_en = 1; #1;
        check({31'b0, rom_dec_en}, 32'h1, "R10 rom with mem_en");
        wr(4'b0010, 32'h0);
        rd(32'h0000_0043, "R2 byte1 write clears serr_en only");
        wr(4'b1100, 32'h0);
        rd(32'h0000_0043, "R2 disabled bytes ignored");
        wr(4'b0001, 32'h0);
        rd(32'h0, "R2 byte0 write clears low enables");
        #4;
        check({31'b0, rom_dec_en}, 32'h0, "R10 rom gated by mem_en");
        rom_bar_en = 0;

        pulse(E_SLV_NI, 0, 0, "R5 slave no irdy");
        pulse(E_MWR_RAW, 0, 0, "R5 master write raw parity");
        rd(32'h0, "R5 unqualified phases ignored");

        pulse(E_SLV, 0, 0, "R11 slave pe with prsp off");
        rd(32'h8000_0000, "R4 slave data pe with prsp off");
        wr(4'b1000, 32'h0);
        rd(32'h8000_0000, "R8 writing 0 keeps flag");
        wr(4'b0111, 32'h8000_0000);
        rd(32'h8000_0000, "R8 byte3 disabled keeps flag");
        wr(4'b1000, 32'h8000_0000);
        rd(32'h0, "R8 W1C clears perr");

        pulse(E_MRD, 0, 0, "R4 master read");
        rd(32'h8000_0000, "R4 master read pe");
        wr(4'b1000, 32'h8000_0000);
        pulse(E_MWR_TP, 0, 0, "R4 master write");
        rd(32'h8000_0000, "R4 target perr on master write");
        wr(4'b1000, 32'h8000_0000);
        pulse(E_ADDR, 0, 0, "R6 addr pe enables off");
        rd(32'h8000_0000, "R6 no serr with enables off");
        wr(4'b1000, 32'h8000_0000);

        wr(4'b0011, 32'h0000_0100);
        pulse(E_ADDR, 0, 0, "R6 serr_en only");
        rd(32'h8000_0100, "R6 serr flag needs prsp_en");
        wr(4'b1011, 32'hF000_0140);
        pulse(E_ADDR, 1, 0, "R6 both enables");
        rd(32'hC000_0140, "R6 serr flag set");
        pulse(E_SLV, 0, 1, "R11 slave pe with prsp on");
        pulse(E_MRD, 0, 1, "R11 master read pe with prsp on");
        wr(4'b1000, 32'hC000_0000);
        rd(32'h0000_0140, "R8 clears both flags");

        pulse(E_MAB, 0, 0, "R7 master abort");
        rd(32'h2000_0140, "R7 mabort flag");
        pulse(E_TAB, 0, 0, "R7 target abort");
        rd(32'h3000_0140, "R7 tabort flag");
        wr(4'b1000, 32'h2000_0000);
        rd(32'h1000_0140, "R8 clears only written flag");

        wr(4'b1000, 32'h1000_0000, E_TAB);
        rd(32'h1000_0140, "R9 set beats clear");
        wr(4'b1000, 32'h1000_0000);
        rd(32'h0000_0140, "R9 later clear works");

        rst_n = 0; #2; rst_n = 1;
        rd(32'h0, "R1 hard reset clears all");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule